// File: doc/BRIEF.md
# Canonical signed-digit recoder

The recoder turns an N-bit two's complement multiplier into its canonical signed-digit form, one digit per step. Every digit is -1, 0 or +1, the set of digits has the fewest nonzero entries that the value allows, and no two neighbouring digits are both nonzero. A multiplier sequencer loads an operand, then raises the advance enable each time it is ready to take the next digit. Digits come out from the least significant position upward.

Each step looks at the current operand bit, the carry left by the step below, and the next higher operand bit, which serves as a reference. It chooses the digit and the carry for the step above. Bits above the top are taken as copies of the sign bit, so N digits always give the signed value exactly. Because the carry chains from one position to the next, the recoding runs serially.

Top module: `csd_recoder`

## Requirements
- R1: A load captures `value`, clears the carry and restarts the run at position 0. In the cycle after a load, `dig_valid` and `done` are both 0. A load that coincides with `advance` produces no digit.
- R2: Each clock edge that sees `advance` high while a run is active and `load` low emits one digit. `dig_valid` is 1 in the cycle after that edge and `dig_pos` gives the digit's position, from 0 up to N-1. A cycle with `advance` low during a run emits nothing and loses nothing.
- R3: Digits are encoded as {`dig_nz`, `dig_neg`}: 00 means 0, 10 means +1 and 11 means -1. The code 01 never appears while `dig_valid` is 1.
- R4: The digit at each step follows from s = operand bit + carry in. s=0 gives digit 0 and carry 0. s=2 gives digit 0 and carry 1. s=1 with reference bit 0 gives +1 and carry 0. s=1 with reference bit 1 gives -1 and carry 1. For operand 01101110 the digits from MSB to LSB are +1 0 0 -1 0 0 -1 0.
- R5: The reference bit for the top position is the sign bit. The N digits weighted by 2^pos sum to the signed value of the operand.
- R6: Two digits emitted at adjacent positions in one run are never both nonzero.
- R7: The number of nonzero digits never exceeds the number of bit changes that radix-2 Booth pairing would give for the same operand (pairs x_i, x_(i-1) with x_(-1)=0).
- R8: `done` rises in the same cycle as `dig_valid` for position N-1 and stays high until the next load. Once the run is over, `advance` produces no further digits.
- R9: A load during a run discards the partial run and starts the new operand from position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture `value` and start a new run |
| value | input | N | Two's complement operand |
| advance | input | 1 | Request the next digit |
| dig_nz | output | 1 | Digit is nonzero |
| dig_neg | output | 1 | Digit is negative (only with `dig_nz`) |
| dig_valid | output | 1 | Digit outputs hold a new digit this cycle |
| dig_pos | output | $clog2(N) | Bit position of the current digit |
| done | output | 1 | Last digit of the run has been emitted |

## Verification
On every cycle the assertions check the digit encoding, that no two adjacent digits are both nonzero, that the final carry matches the sign bit, and that a load or an idle state gives no digit. They also check that `done` rises only together with a digit and that a stalled run keeps its place. Whether the digit string is the minimal one and sums to the operand cannot be seen one cycle at a time. The bench shows this by sweeping every 8-bit operand, with stalls in the advance pattern, and comparing each digit string with a non-adjacent form computed arithmetically. It also counts the nonzero digits against the Booth count and checks the restart and load-priority cases.

// File: rtl/csd_pkg.sv
package csd_pkg;

  typedef struct packed {
    logic nz;
    logic neg;
  } csd_digit_t;

  typedef struct packed {
    csd_digit_t dig;
    logic       cout;
  } csd_step_t;

  // One recoding step: operand bit, incoming carry, next higher bit as reference.
  function automatic csd_step_t csd_step(input logic xb, input logic cin, input logic xref);
    csd_step_t  r;
    logic [1:0] s;
    s = {1'b0, xb} + {1'b0, cin};
    r = '0;
    case (s)
      2'd0: begin
        r.dig  = '0;
        r.cout = 1'b0;
      end
      2'd2: begin
        r.dig  = '0;
        r.cout = 1'b1;
      end
      default: begin
        if (xref) begin
          r.dig.nz  = 1'b1;
          r.dig.neg = 1'b1;
          r.cout    = 1'b1;
        end else begin
          r.dig.nz  = 1'b1;
          r.dig.neg = 1'b0;
          r.cout    = 1'b0;
        end
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/csd_digit_rule.sv
module csd_digit_rule
  import csd_pkg::*;
(
  input  logic       xb,
  input  logic       cin,
  input  logic       xref,
  output csd_digit_t dig,
  output logic       cout
);
  csd_step_t res;

  always_comb begin
    res  = csd_step(xb, cin, xref);
    dig  = res.dig;
    cout = res.cout;
  end

  // R3: the rule never yields a negative zero
  always_comb begin
    assert_rule_code_R3: assert (!(dig.neg && !dig.nz));
  end
endmodule

// File: rtl/csd_bit_sequencer.sv
module csd_bit_sequencer #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [N-1:0]         value,
  input  logic                 advance,
  input  logic                 cout_in,
  output logic                 cur_bit,
  output logic                 ref_bit,
  output logic                 carry,
  output logic [$clog2(N)-1:0] pos,
  output logic                 busy,
  output logic                 step_fire,
  output logic                 last_step
);
  localparam int PW = $clog2(N);
  localparam logic [PW-1:0] LAST_POS = PW'(N - 1);

  logic [N-1:0] sh_q;

  assign cur_bit   = sh_q[0];
  assign ref_bit   = sh_q[1];
  assign step_fire = busy & advance & ~load;
  assign last_step = (pos == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      carry <= 1'b0;
      pos   <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      sh_q  <= value;
      carry <= 1'b0;
      pos   <= '0;
      busy  <= 1'b1;
    end else if (step_fire) begin
      // arithmetic shift keeps the sign bit as the reference above the top
      sh_q  <= {sh_q[N-1], sh_q[N-1:1]};
      carry <= cout_in;
      pos   <= pos + 1'b1;
      if (last_step) busy <= 1'b0;
    end
  end

  // R5: the carry leaving the top position equals the sign bit
  assert_final_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && last_step) |-> (cout_in == cur_bit));

  // R2: a stalled run keeps its position and stays active
  assert_stall_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && !advance) |=> (busy && $stable(pos)));
endmodule

// File: rtl/csd_digit_out.sv
module csd_digit_out
  import csd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 step_fire,
  input  logic                 last_step,
  input  csd_digit_t           dig_in,
  input  logic [$clog2(N)-1:0] pos_in,
  output logic                 dig_nz,
  output logic                 dig_neg,
  output logic                 dig_valid,
  output logic [$clog2(N)-1:0] dig_pos,
  output logic                 done
);
  logic prev_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_nz    <= 1'b0;
      dig_neg   <= 1'b0;
      dig_valid <= 1'b0;
      dig_pos   <= '0;
      done      <= 1'b0;
    end else if (load) begin
      dig_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      dig_valid <= step_fire;
      if (step_fire) begin
        dig_nz  <= dig_in.nz;
        dig_neg <= dig_in.neg;
        dig_pos <= pos_in;
        if (last_step) done <= 1'b1;
      end
    end
  end

  // last emitted digit of the current run, for the adjacency check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prev_nz <= 1'b0;
    else if (load)      prev_nz <= 1'b0;
    else if (dig_valid) prev_nz <= dig_nz;
  end

  assert_no_adjacent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid && prev_nz) |-> !dig_nz);

  assert_digit_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid |-> !(dig_neg && !dig_nz));

  assert_done_with_digit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> dig_valid);
endmodule

// File: rtl/csd_recoder.sv
module csd_recoder
  import csd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [N-1:0]         value,
  input  logic                 advance,
  output logic                 dig_nz,
  output logic                 dig_neg,
  output logic                 dig_valid,
  output logic [$clog2(N)-1:0] dig_pos,
  output logic                 done
);
  localparam int PW = $clog2(N);

  logic          cur_bit;
  logic          ref_bit;
  logic          carry;
  logic          cout;
  logic [PW-1:0] pos;
  logic          busy;
  logic          step_fire;
  logic          last_step;
  csd_digit_t    step_dig;

  csd_bit_sequencer #(.N(N)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .value     (value),
    .advance   (advance),
    .cout_in   (cout),
    .cur_bit   (cur_bit),
    .ref_bit   (ref_bit),
    .carry     (carry),
    .pos       (pos),
    .busy      (busy),
    .step_fire (step_fire),
    .last_step (last_step)
  );

  csd_digit_rule u_rule (
    .xb   (cur_bit),
    .cin  (carry),
    .xref (ref_bit),
    .dig  (step_dig),
    .cout (cout)
  );

  csd_digit_out #(.N(N)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step_fire (step_fire),
    .last_step (last_step),
    .dig_in    (step_dig),
    .pos_in    (pos),
    .dig_nz    (dig_nz),
    .dig_neg   (dig_neg),
    .dig_valid (dig_valid),
    .dig_pos   (dig_pos),
    .done      (done)
  );

  // R1 (and R10 case of load with advance): a load is followed by a quiet cycle
  assert_load_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!dig_valid && !done));

  // R8: no digit appears when no run is active
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> !dig_valid);
endmodule

// File: tb/csd_recoder_tb.sv
module csd_recoder_tb;
  localparam int N  = 8;
  localparam int PW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [N-1:0]  value = '0;
  logic          advance = 1'b0;
  logic          dig_nz, dig_neg, dig_valid, done;
  logic [PW-1:0] dig_pos;

  int errors = 0;
  int checks = 0;
  int exp_d [N];
  bit finished = 0;

  always #10 clk = ~clk;

  csd_recoder #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .value(value), .advance(advance),
    .dig_nz(dig_nz), .dig_neg(dig_neg), .dig_valid(dig_valid),
    .dig_pos(dig_pos), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int signed_of(input logic [N-1:0] v);
    int s;
    s = int'(v);
    if (v[N-1]) s = s - (1 << N);
    return s;
  endfunction

  // non-adjacent form by repeated halving
  task automatic build_naf(input logic [N-1:0] v);
    int r;
    r = signed_of(v);
    for (int k = 0; k < N; k++) begin
      if ((r & 1) != 0) begin
        exp_d[k] = ((r & 3) == 1) ? 1 : -1;
        r = r - exp_d[k];
      end else begin
        exp_d[k] = 0;
      end
      r = r / 2;
    end
  endtask

  function automatic int booth_weight(input logic [N-1:0] v);
    int w;
    logic prev;
    w = 0;
    prev = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (v[k] != prev) w++;
      prev = v[k];
    end
    return w;
  endfunction

  function automatic int dig_val();
    return dig_nz ? (dig_neg ? -1 : 1) : 0;
  endfunction

  task automatic do_load(input logic [N-1:0] v, input logic adv);
    @(negedge clk);
    load = 1'b1;
    value = v;
    advance = adv;
    @(negedge clk);
    load = 1'b0;
    advance = 1'b0;
    check(!dig_valid && !done, "R1 quiet after load", {dig_valid, done}, 0);
  endtask

  task automatic run_value(input logic [N-1:0] v, input int stall_mod);
    int k, sum, nzc, prev, guard, d;
    build_naf(v);
    do_load(v, 1'b0);
    k = 0; sum = 0; nzc = 0; prev = 0; guard = 0;
    while (k < N && guard < 4 * N) begin
      guard++;
      advance = (stall_mod == 0) || ((guard % stall_mod) != 0);
      @(negedge clk);
      if (advance) begin
        d = dig_val();
        check(dig_valid && dig_pos == PW'(k), "R2 digit position", int'(dig_pos), k);
        check(!(dig_neg && !dig_nz), "R3 encoding", {dig_nz, dig_neg}, 2);
        check(d == exp_d[k], "R4 digit value", d, exp_d[k]);
        check(!(d != 0 && prev != 0), "R6 adjacent nonzero", d, 0);
        check(done == (k == N - 1), "R8 done timing", done, k == N - 1);
        sum += d * (1 << k);
        if (d != 0) nzc++;
        prev = d;
        k++;
      end else begin
        check(!dig_valid, "R2 stall emits nothing", dig_valid, 0);
      end
    end
    advance = 1'b0;
    check(sum == signed_of(v), "R5 digit sum", sum, signed_of(v));
    check(nzc <= booth_weight(v), "R7 weight vs booth", nzc, booth_weight(v));
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check(!dig_valid && done, "R8 idle advance after run", {dig_valid, done}, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(!dig_valid && !done, "R1 reset state", {dig_valid, done}, 0);
    rst_n = 1'b1;

    // R4 worked example: 01101110 -> +1 0 0 -1 0 0 -1 0 (MSB first)
    build_naf(8'b01101110);
    check(exp_d[7] == 1 && exp_d[4] == -1 && exp_d[1] == -1, "R4 example model", exp_d[4], -1);
    run_value(8'b01101110, 0);

    // exhaustive sweep, with and without stalls
    for (int v = 0; v < (1 << N); v++) begin
      run_value(N'(v), (v % 4 == 1) ? 3 : 0);
    end

    // R9: restart mid-run
    do_load(8'b01010101, 1'b0);
    advance = 1'b1;
    repeat (3) @(negedge clk);
    advance = 1'b0;
    run_value(8'b11100011, 2);

    // R1/R10 case: load together with advance gives no digit
    do_load(8'b00000111, 1'b1);
    @(negedge clk);
    check(!dig_valid, "R1 load beats advance", dig_valid, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule